// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital side of a 16-bit successive-approximation converter's serial port. Its three serial pins (conversion start, serial clock and serial data in) are brought into a fast system clock domain through two-stage synchronizers. The block latches an interface mode on every accepted conversion-start rising edge. When the converter core signals that a conversion is finished, it returns the 16-bit result on a serial data output that can be tri-stated.

There are two families of operation. The first is select mode. Here the conversion-start pin or the serial-data-in pin acts as an active-low output enable, in either a 3-wire or a 4-wire style. An optional low start bit flags the end of the conversion. The second is chain mode. Here the internal shift register passes serial-data-in through to the output, so that several converters can be read over one line. Chain mode can also carry a busy flag that ripples toward the host.

The conversion-done pulse and the result word come from the converter core, which is outside this block. SDO is modelled as a data bit plus an active-high output enable.

Top module: `serial_out_port`

## Requirements
- R1: After reset, with the conversion-start and data-in pins held high, the output enable is low.
- R2: Mode latching happens at a conversion-start rising edge that arrives while no conversion is running. Data-in high selects select mode and data-in low selects chain mode. In chain mode, a high serial clock at that edge enables the busy bit. A rising edge that arrives while a conversion is running changes nothing.
- R3: In select mode, if the enable is inactive when the conversion completes, the output stays undriven. Once the enable goes active, the result's MSB is driven. The enable is active when conversion-start or data-in is low. Each later synchronized serial-clock falling edge advances one bit. The result is straight binary, MSB first.
- R4: In select mode, if the enable is already active when the conversion completes, a low start bit is driven first. The first serial-clock falling edge then presents the MSB.
- R5: In select mode, the output returns to undriven after the 16th falling edge, or after the 17th when the start bit was sent. Further falling edges leave it undriven.
- R6: In select mode, if both conversion-start and data-in go high during a readout, the output becomes undriven and that readout is abandoned. Re-enabling does not resume it.
- R7: In select mode, an accepted conversion-start rising edge makes the output undriven.
- R8: In chain mode the output is always driven.
  - Before the conversion completes, the output is low and serial-clock edges are ignored.
  - At completion, the MSB is driven.
  - Each falling edge shifts data-in into the register, so a data-in bit reappears on the output 16 falling edges after it was shifted in.
- R9: In chain mode with the busy bit, the output follows data-in from the moment the device's own conversion completes until the first falling edge. That edge presents the MSB and does not capture data-in.
- R10: Whenever synchronized conversion-start and data-in are both low, the output is driven. In select mode with no readout active, it is driven low.
- R11: A conversion-done pulse that coincides with an accepted conversion-start rising edge completes the running conversion. That rising edge is ignored, and the finished result stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Conversion-start pin (asynchronous) |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data-in pin (asynchronous) |
| conv_done_i | input | 1 | One-cycle conversion-complete pulse from the converter core |
| result_i | input | DATA_W | Conversion result, valid with conv_done_i |
| sdo_o | output | 1 | Serial data out (0 when not driven) |
| sdo_oe_o | output | 1 | Output enable for sdo_o, active high |

## Verification
Two functions can fall in the same system-clock cycle. One is the completion pulse of a running conversion. The other is the detection of a fresh conversion-start rising edge. The bench raises the start pin exactly two cycles before it drives the done pulse, so the synchronized edge and the pulse are sampled at the same clock edge. It then judges the result by lowering the start pin: the MSB of the just-finished result must appear, and no new conversion may have begun. Every cycle, a behavioural model built from queues and integers is also compared with the output and its enable.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic {
    MODE_SEL   = 1'b0,
    MODE_CHAIN = 1'b1
  } sop_mode_e;
endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sop_mode.sv
module sop_mode
  import sop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cnv_rise_i,
  input  logic      sdi_i,
  input  logic      sck_i,
  input  logic      done_i,
  output sop_mode_e mode_o,
  output logic      chain_busy_o,
  output logic      conv_o,
  output logic      start_o,
  output logic      done_o
);
  sop_mode_e mode_q;
  logic      cbusy_q, conv_q;

  // a rising edge mid-conversion is ignored
  assign start_o = cnv_rise_i & ~conv_q;
  assign done_o  = done_i & conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SEL;
      cbusy_q <= 1'b0;
      conv_q  <= 1'b0;
    end else if (start_o) begin
      mode_q  <= sdi_i ? MODE_SEL : MODE_CHAIN;
      cbusy_q <= sck_i;
      conv_q  <= 1'b1;
    end else if (done_o) begin
      conv_q  <= 1'b0;
    end
  end

  assign mode_o       = mode_q;
  assign chain_busy_o = cbusy_q;
  assign conv_o       = conv_q;
endmodule

// File: rtl/sop_shift.sv
module sop_shift
  import sop_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  sop_mode_e         mode_i,
  input  logic              chain_busy_i,
  input  logic              en_i,
  input  logic              en_drop_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic              cnv_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              active, bphase, ready;
  logic              chain;

  assign chain = (mode_i == MODE_CHAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      bphase <= 1'b0;
      ready  <= 1'b0;
    end else if (start_i) begin
      active <= 1'b0;
      ready  <= 1'b0;
      bphase <= 1'b0;
    end else if (done_i) begin
      sreg <= result_i;
      cnt  <= '0;
      if (chain) begin
        ready  <= 1'b1;
        bphase <= chain_busy_i;
      end else begin
        active <= 1'b1;
        bphase <= en_i;
      end
    end else if (chain) begin
      if (ready && sck_fall_i) begin
        if (bphase) bphase <= 1'b0;
        else        sreg   <= {sreg[DATA_W-2:0], sdi_i};
      end
    end else if (active) begin
      if (en_drop_i) begin
        active <= 1'b0;
      end else if (en_i && sck_fall_i) begin
        if (bphase) begin
          bphase <= 1'b0;
        end else begin
          sreg <= {sreg[DATA_W-2:0], 1'b0};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST) active <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sdo_oe_o = 1'b0;
    sdo_o    = 1'b0;
    if (chain) begin
      sdo_oe_o = 1'b1;
      sdo_o    = bphase ? (ready & sdi_i) : (ready & sreg[DATA_W-1]);
    end else if (active && en_i) begin
      sdo_oe_o = 1'b1;
      sdo_o    = ~bphase & sreg[DATA_W-1];
    end else if (!cnv_i && !sdi_i) begin
      sdo_oe_o = 1'b1;
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/serial_out_port.sv
module serial_out_port
  import sop_pkg::*;
#(
  parameter  int DATA_W      = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  // pin order in the sync vector: {cnv, sdi, sck}
  logic [2:0] pins_s;
  logic       cnv_s, sdi_s, sck_s;
  logic       cnv_q, sck_q, en_q;
  logic       cnv_rise, sck_fall, en, en_drop;
  sop_mode_e  mode;
  logic       chain_busy, conv_run, start, done_evt;
  logic [CNT_W-1:0] sel_cnt;

  sop_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cnv_i, sdi_i, sck_i}),
    .q_o   (pins_s)
  );

  assign {cnv_s, sdi_s, sck_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_q <= 1'b1;
      sck_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      cnv_q <= cnv_s;
      sck_q <= sck_s;
      en_q  <= en;
    end
  end

  assign cnv_rise = cnv_s & ~cnv_q;
  assign sck_fall = ~sck_s & sck_q;
  assign en       = ~(cnv_s & sdi_s);
  assign en_drop  = en_q & ~en;

  sop_mode i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnv_rise_i  (cnv_rise),
    .sdi_i       (sdi_s),
    .sck_i       (sck_s),
    .done_i      (conv_done_i),
    .mode_o      (mode),
    .chain_busy_o(chain_busy),
    .conv_o      (conv_run),
    .start_o     (start),
    .done_o      (done_evt)
  );

  sop_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .done_i      (done_evt),
    .mode_i      (mode),
    .chain_busy_i(chain_busy),
    .en_i        (en),
    .en_drop_i   (en_drop),
    .sck_fall_i  (sck_fall),
    .sdi_i       (sdi_s),
    .cnv_i       (cnv_s),
    .result_i    (result_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .cnt_o       (sel_cnt)
  );
endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter  int DATA_W = 16,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnv_s,
  input logic             sdi_s,
  input logic             start,
  input logic             done_evt,
  input logic             conv_run,
  input logic             is_chain,
  input logic             en,
  input logic [CNT_W-1:0] sel_cnt,
  input logic             sdo_o,
  input logic             sdo_oe_o
);
  AST_CHAIN_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_chain |-> sdo_oe_o); // R8

  AST_START_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && sdi_s) |=> (!sdo_oe_o || !cnv_s)); // R7

  AST_BUSY_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt && !is_chain && en) |=> ((sdo_oe_o && !sdo_o) || !en)); // R4

  AST_BOTH_LOW_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnv_s && !sdi_s) |-> sdo_oe_o); // R10

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cnt <= CNT_W'(DATA_W)); // R5

  AST_DONE_ENDS_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt |=> !conv_run); // R11
endmodule

bind serial_out_port sop_checker #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnv_s   (cnv_s),
  .sdi_s   (sdi_s),
  .start   (start),
  .done_evt(done_evt),
  .conv_run(conv_run),
  .is_chain(mode == sop_pkg::MODE_CHAIN),
  .en      (en),
  .sel_cnt (sel_cnt),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o)
);

// File: tb/test_serial_out_port.sv
`timescale 1ns/1ps
module test_serial_out_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cnv_i = 1'b1, sck_i = 1'b0, sdi_i = 1'b1, conv_done_i = 1'b0;
  logic [W-1:0] result_i = '0;
  logic sdo_o, sdo_oe_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_out_port i_serial_out_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnv_i(cnv_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .conv_done_i(conv_done_i), .result_i(result_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  // ---------------- behavioural reference model ----------------
  bit c1, c2, cq, k1, k2, kq, d1, d2, eq;
  bit m_chain, m_cb, m_conv, m_act, m_bp, m_rdy;
  int m_left;
  bit [W-1:0] m_word;
  bit m_q[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1 = 1; c2 = 1; cq = 1; d1 = 1; d2 = 1; k1 = 0; k2 = 0; kq = 0; eq = 0;
      m_chain = 0; m_cb = 0; m_conv = 0; m_act = 0; m_bp = 0; m_rdy = 0;
      m_left = 0; m_word = '0; m_q.delete();
    end else begin
      bit en_v, rise_ok, dn, fall, drop, ch;
      en_v    = !(c2 && d2);
      rise_ok = c2 && !cq && !m_conv;
      dn      = conv_done_i && m_conv;
      fall    = !k2 && kq;
      drop    = eq && !en_v;
      ch      = m_chain;
      if (rise_ok) begin m_chain = !d2; m_cb = k2; m_conv = 1; end
      else if (dn) m_conv = 0;
      if (rise_ok) begin m_act = 0; m_rdy = 0; m_bp = 0; end
      else if (dn) begin
        if (ch) begin
          m_rdy = 1; m_bp = m_cb; m_q.delete();
          for (int i = W-1; i >= 0; i--) m_q.push_back(result_i[i]);
        end else begin
          m_act = 1; m_bp = en_v; m_word = result_i; m_left = W;
        end
      end else if (ch) begin
        if (m_rdy && fall) begin
          if (m_bp) m_bp = 0;
          else begin void'(m_q.pop_front()); m_q.push_back(d2); end
        end
      end else if (m_act) begin
        if (drop) m_act = 0;
        else if (en_v && fall) begin
          if (m_bp) m_bp = 0;
          else begin m_left--; if (m_left == 0) m_act = 0; end
        end
      end
      eq = en_v; cq = c2; kq = k2;
      c2 = c1; k2 = k1; d2 = d1;
      c1 = cnv_i; k1 = sck_i; d1 = sdi_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit m_oe, m_d;
      m_oe = 0; m_d = 0;
      if (m_chain) begin
        m_oe = 1;
        if (m_bp) m_d = m_rdy && d2;
        else if (m_rdy) m_d = m_q[0];
      end else if (m_act && !(c2 && d2)) begin
        m_oe = 1;
        m_d = m_bp ? 1'b0 : m_word[m_left-1];
      end else if (!c2 && !d2) m_oe = 1;
      checks++;
      if (sdo_oe_o !== m_oe || (m_oe && sdo_o !== m_d)) begin
        errors++;
        $display("FAIL R3 model t=%0t oe/sdo actual %b/%b expected %b/%b",
                 $time, sdo_oe_o, sdo_o, m_oe, m_d);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_conv(input bit sdi_lvl, input bit sck_lvl);
    cnv_i = 0; sdi_i = sdi_lvl; sck_i = sck_lvl;
    step(3);
    cnv_i = 1;
    step(5);
  endtask

  task automatic finish_conv(input logic [W-1:0] word, input bit cnv_lvl, input bit sdi_lvl);
    cnv_i = cnv_lvl; sdi_i = sdi_lvl;
    step(3);
    result_i = word; conv_done_i = 1;
    step(1);
    conv_done_i = 0;
    step(3);
  endtask

  task automatic pulse();
    sck_i = 1; step(3);
    sck_i = 0; step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    logic [31:0] w2;
    step(3);
    rst_ni = 1;
    step(2);
    chk("R1 oe after reset", sdo_oe_o, 0);

    // select, 3-wire, no start bit
    start_conv(1, 0);
    finish_conv(16'hA5C3, 1, 1);
    chk("R3 undriven while enable off", sdo_oe_o, 0);
    cnv_i = 0; step(3);
    chk("R3 oe on enable", sdo_oe_o, 1);
    w[15] = sdo_o;
    for (int i = 14; i >= 0; i--) begin pulse(); w[i] = sdo_o; end
    chk("R3 word", w, 16'hA5C3);
    pulse();
    chk("R5 hiz after 16 falls", sdo_oe_o, 0);
    pulse();
    chk("R5 extra fall stays hiz", sdo_oe_o, 0);
    sdi_i = 0; step(3);
    chk("R10 both low driven", {sdo_oe_o, sdo_o}, 2'b10);

    // select, 3-wire, with start bit
    start_conv(1, 0);
    finish_conv(16'h3C01, 0, 1);
    chk("R4 start bit 3-wire", {sdo_oe_o, sdo_o}, 2'b10);
    for (int i = 15; i >= 0; i--) begin pulse(); w[i] = sdo_o; end
    chk("R4 word 3-wire", w, 16'h3C01);
    chk("R5 still driven before 17th", sdo_oe_o, 1);
    pulse();
    chk("R5 hiz after 17 falls", sdo_oe_o, 0);

    // select, 4-wire, with start bit
    start_conv(1, 0);
    finish_conv(16'hFFFE, 1, 0);
    chk("R4 start bit 4-wire", {sdo_oe_o, sdo_o}, 2'b10);
    for (int i = 15; i >= 0; i--) begin pulse(); w[i] = sdo_o; end
    chk("R4 word 4-wire", w, 16'hFFFE);
    pulse();
    chk("R5 hiz 4-wire", sdo_oe_o, 0);

    // select, 4-wire abort
    start_conv(1, 0);
    finish_conv(16'h8001, 1, 1);
    sdi_i = 0; step(3);
    chk("R3 msb on data-in enable", {sdo_oe_o, sdo_o}, 2'b11);
    pulse(); pulse(); pulse();
    sdi_i = 1; step(3);
    chk("R6 abort hiz", sdo_oe_o, 0);
    sdi_i = 0; step(3);
    chk("R6 no resume", sdo_oe_o, 0);

    // start edge forces hi-Z mid-readout
    start_conv(1, 0);
    finish_conv(16'h1234, 0, 1);
    pulse(); pulse();
    chk("R4 readout in progress", sdo_oe_o, 1);
    cnv_i = 1; step(3);
    chk("R7 start edge hiz", sdo_oe_o, 0);
    finish_conv(16'h0000, 1, 1);

    // chain, no busy
    start_conv(0, 0);
    chk("R2 chain selected, low before done", {sdo_oe_o, sdo_o}, 2'b10);
    pulse();
    chk("R8 fall before done ignored", {sdo_oe_o, sdo_o}, 2'b10);
    finish_conv(16'hC35A, 1, 0);
    chk("R8 msb at done", {sdo_oe_o, sdo_o}, 2'b11);
    for (int j = 0; j < 32; j++) begin
      w2[31-j] = sdo_o;
      sdi_i = (j < 16) ? ((16'h96E1 >> (15-j)) & 1) : 1'b0;
      pulse();
    end
    chk("R8 result then passthrough", w2, {16'hC35A, 16'h96E1});

    // chain with busy bit
    start_conv(0, 1);
    sck_i = 0; step(4);
    finish_conv(16'h7E81, 1, 0);
    chk("R9 busy follows low data-in", {sdo_oe_o, sdo_o}, 2'b10);
    sdi_i = 1; step(3);
    chk("R9 busy high", {sdo_oe_o, sdo_o}, 2'b11);
    for (int i = 15; i >= 0; i--) begin pulse(); w[i] = sdo_o; end
    chk("R9 word after busy", w, 16'h7E81);

    // rising edge during conversion ignored
    start_conv(0, 0);
    cnv_i = 0; sdi_i = 1; step(3);
    cnv_i = 1; step(4);
    finish_conv(16'h8F00, 1, 1);
    chk("R2 mode kept", {sdo_oe_o, sdo_o}, 2'b11);

    // done coincident with start edge
    start_conv(1, 0);
    cnv_i = 0; sdi_i = 1; step(3);
    cnv_i = 1; step(2);
    result_i = 16'hB00F; conv_done_i = 1;
    step(1);
    conv_done_i = 0; step(3);
    chk("R11 hiz while disabled", sdo_oe_o, 0);
    cnv_i = 0; step(3);
    chk("R11 finished result readable", {sdo_oe_o, sdo_o}, 2'b11);
    pulse();
    chk("R11 second bit", sdo_o, 0);

    step(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule